// File: doc/BRIEF.md
# Hamming Sector Check-and-Repair Engine

This engine finishes the error check on one 512-byte storage sector that is guarded by a 3-byte single-error-correcting Hamming code. When started, it takes two 3-byte codes. One is the code read back from the spare area. The other is the code recomputed from the sector data as it streamed in. Each code is spread into a 32-bit word with a split-nibble layout. The two words are XORed, and the number of set bits in the difference is counted by a pipelined adder tree.

The size of the difference decides the outcome: clean, repairable, damaged code field, blank (freshly erased) sector, or beyond repair. In the repairable case, the difference also gives the location of the bad bit. The engine then fetches that byte from the sector buffer, flips the bit and writes the byte back. A one-cycle done pulse carries a 3-bit status. Producing the recomputed code, and all media timing, belong to other blocks.

Top module: `hamming_sector_fixer`

## Requirements
- R1: A 24-bit code input holds byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. It is packed into 32 bits as follows: byte 0 goes to bits 7:0 and byte 1 to bits 23:16. The high nibble of byte 2 goes to bits 27:24 and its low nibble to bits 11:8. Bits 31:28 and 15:12 are zero.
- R2: If the packed stored and computed words are equal, status is 0 (clean) and the sector buffer is not accessed.
- R3: If the XOR of the packed words has exactly 12 set bits, status is 1 (corrected). The byte at address XOR[27:19] gets bit XOR[18:16] inverted, and every other byte is left unchanged.
- R4: If the XOR has exactly one set bit, status is 2 (code field damaged) and the buffer is not accessed.
- R5: If the packed stored word is 0x0FFF0FFF and the packed computed word is zero, status is 3 (erased) and the buffer is not accessed.
- R6: Any other nonzero XOR gives status 4 (uncorrectable), with no buffer access.
- R7: `done` is a single-cycle pulse. It is high in the 4th cycle after the clock edge that samples `start` when no repair is needed, and in the 6th cycle when a repair is made.
- R8: A repair makes exactly one buffer read and then, in the next cycle, exactly one write to the same address. The buffer returns read data one cycle after the read strobe.
- R9: A `start` that arrives while an operation is in progress is ignored and does not change that operation's result.
- R10: During and just after reset, `done`, `buf_rd_en` and `buf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; sampled only while idle |
| stored_code | input | 24 | Code bytes read from spare storage |
| calc_code | input | 24 | Code bytes recomputed over the data |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rd_data | input | 8 | Buffer read data, one cycle after the strobe |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | 8 | Repaired byte |
| done | output | 1 | Result pulse |
| status | output | 3 | Outcome code, valid with done |

## Verification
Code pairs are drawn at random for five cases: identical codes, a single flipped code bit, a two-bit difference, the blank-sector pair, and a constructed single-data-bit syndrome. The single-bit case separates code-field damage from a repair. The 12-bit syndromes, placed at random bytes and bits, show whether the split-nibble packing and the address and bit extraction are right. The buffer is compared byte by byte after every case, and reads and writes are counted, so a wrong address, a wrong mask or a stray access shows up. A second start while the engine is busy checks that the first result survives.

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer #(
  parameter int SECTOR_BYTES = 512,
  parameter int SLICE_W      = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [23:0]                     stored_code,
  input  logic [23:0]                     calc_code,
  output logic [$clog2(SECTOR_BYTES)-1:0] buf_addr,
  output logic                            buf_rd_en,
  input  logic [7:0]                      buf_rd_data,
  output logic                            buf_wr_en,
  output logic [7:0]                      buf_wr_data,
  output logic                            done,
  output logic [2:0]                      status
);
  localparam int WORD_W = 32;
  localparam int NSLICE = WORD_W / SLICE_W;
  localparam int SCNT_W = $clog2(SLICE_W + 1);
  localparam int TCNT_W = $clog2(WORD_W + 1);
  localparam int ADDR_W = $clog2(SECTOR_BYTES);

  localparam logic [2:0] ST_CLEAN = 3'd0;
  localparam logic [2:0] ST_FIXED = 3'd1;
  localparam logic [2:0] ST_CODE  = 3'd2;
  localparam logic [2:0] ST_BLANK = 3'd3;
  localparam logic [2:0] ST_BAD   = 3'd4;

  typedef enum logic [2:0] {IDLE, CNT1, CNT2, DECIDE, RD, WR} state_t;
  state_t state;

  function automatic logic [WORD_W-1:0] pack(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  logic [WORD_W-1:0] diff_q;
  logic              blank_q;
  logic [SCNT_W-1:0] slice_cnt [NSLICE];
  logic [TCNT_W-1:0] total_q;
  logic [TCNT_W-1:0] total_d;

  always_comb begin
    total_d = '0;
    for (int i = 0; i < NSLICE; i++) total_d += TCNT_W'(slice_cnt[i]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLICE; i++)
      slice_cnt[i] <= SCNT_W'($countones(diff_q[i*SLICE_W +: SLICE_W]));
    total_q <= total_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      diff_q  <= '0;
      blank_q <= 1'b0;
      done    <= 1'b0;
      status  <= ST_CLEAN;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          diff_q  <= pack(stored_code) ^ pack(calc_code);
          blank_q <= (pack(stored_code) == 32'h0FFF0FFF) && (calc_code == 24'h0);
          state   <= CNT1;
        end
        CNT1: state <= CNT2;
        CNT2: state <= DECIDE;
        DECIDE: begin
          if (total_q == TCNT_W'(12)) state <= RD;
          else begin
            done  <= 1'b1;
            state <= IDLE;
            if (total_q == '0)               status <= ST_CLEAN;
            else if (total_q == TCNT_W'(1)) status <= ST_CODE;
            else if (blank_q)               status <= ST_BLANK;
            else                            status <= ST_BAD;
          end
        end
        RD: state <= WR;
        WR: begin
          done   <= 1'b1;
          status <= ST_FIXED;
          state  <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign buf_addr    = diff_q[19 +: ADDR_W];
  assign buf_rd_en   = (state == RD);
  assign buf_wr_en   = (state == WR);
  assign buf_wr_data = buf_rd_data ^ (8'd1 << diff_q[18:16]);
endmodule

module hamming_sector_fixer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] buf_addr,
  input logic       buf_rd_en,
  input logic       buf_wr_en,
  input logic       done,
  input logic [2:0] status
);
  p_rd_then_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> buf_wr_en && $stable(buf_addr));
  p_wr_only_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> !buf_rd_en && $past(buf_rd_en));
  p_wr_then_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> done && status == 3'd1);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_no_access_unfixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 3'd1) |-> !$past(buf_wr_en) && !buf_rd_en);
  p_status_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status <= 3'd4);
endmodule

bind hamming_sector_fixer hamming_sector_fixer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .buf_addr(buf_addr), .buf_rd_en(buf_rd_en),
  .buf_wr_en(buf_wr_en), .done(done), .status(status));

// File: tb/hamming_sector_fixer_tb_top.sv
module hamming_sector_fixer_tb_top;
  logic clk = 0, rst_n = 0, start = 0;
  logic [23:0] stored_code = 0, calc_code = 0;
  logic [8:0] buf_addr;
  logic buf_rd_en, buf_wr_en, done;
  logic [7:0] buf_rd_data, buf_wr_data;
  logic [2:0] status;

  always #4 clk = ~clk;

  hamming_sector_fixer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored_code),
    .calc_code(calc_code), .buf_addr(buf_addr), .buf_rd_en(buf_rd_en),
    .buf_rd_data(buf_rd_data), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
    .done(done), .status(status));

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  int total = 0, bad = 0;

  always @(posedge clk) begin
    if (buf_rd_en) begin buf_rd_data <= mem[buf_addr]; rd_cnt <= rd_cnt + 1; end
    if (buf_wr_en) begin mem[buf_addr] <= buf_wr_data; wr_cnt <= wr_cnt + 1; end
    if (done) done_cnt <= done_cnt + 1;
  end

  function automatic logic [31:0] pk(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic int exp_status(input logic [23:0] s, input logic [23:0] c);
    logic [31:0] d;
    d = pk(s) ^ pk(c);
    if (d == 0) return 0;
    if ($countones(d) == 12) return 1;
    if ($countones(d) == 1) return 2;
    if (pk(s) == 32'h0FFF0FFF && pk(c) == 0) return 3;
    return 4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [23:0] s, input logic [23:0] c, input bit busy_poke);
    int es, n, r0, w0, d0, mism;
    logic [31:0] d;
    es = exp_status(s, c);
    d = pk(s) ^ pk(c);
    if (es == 1) exp_mem[d[27:19]] = exp_mem[d[27:19]] ^ (8'd1 << d[18:16]);
    r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt;
    @(negedge clk);
    stored_code = s; calc_code = c; start = 1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (busy_poke && n == 1) begin
        stored_code = ~s; calc_code = c ^ 24'h000003;
      end else if (!busy_poke || n > 2) start = 0;
    end while (!done && n < 20);
    start = 0;
    chk(busy_poke ? "R9 status" : "R2-R6 status", int'(status), es);
    chk("R7 latency", n, es == 1 ? 6 : 4);
    @(negedge clk);
    chk("R7 single pulse", int'(done), 0);
    repeat (4) @(negedge clk);
    chk("R7 done count", done_cnt - d0, 1);
    chk("R8 reads", rd_cnt - r0, es == 1 ? 1 : 0);
    chk("R8 writes", wr_cnt - w0, es == 1 ? 1 : 0);
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk("R3 R1 buffer mismatches", mism, 0);
  endtask

  function automatic logic [23:0] fix_syndrome(input int byte_i, input int bit_i);
    logic [11:0] hi, lo;
    hi = {byte_i[8:0], bit_i[2:0]};
    lo = ~hi;
    return {hi[11:8], lo[11:8], hi[7:0], lo[7:0]};
  endfunction

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] c, x;
    int k, b1, b2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin mem[i] = 8'($urandom); exp_mem[i] = mem[i]; end
    repeat (3) @(negedge clk);
    chk("R10 done in reset", int'(done), 0);
    chk("R10 rd in reset", int'(buf_rd_en), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 wr after reset", int'(buf_wr_en), 0);

    run_case(24'hFFFFFF, 24'h000000, 0);          // R5 blank sector
    run_case(24'hFFFFFF, 24'hFFFFFF, 0);          // R2
    run_case(24'h123456 ^ fix_syndrome(0, 0), 24'h123456, 0);     // R3 first byte
    run_case(24'h0ABCDE ^ fix_syndrome(511, 7), 24'h0ABCDE, 0);   // R3 last byte
    run_case(24'h800000, 24'h000000, 0);          // R4 nibble-high bit
    run_case(24'h0FFF0F ^ 24'h0, 24'h000000, 0);  // R6 near-blank pattern
    run_case(24'h5A5A5A ^ fix_syndrome(77, 3), 24'h5A5A5A, 1);    // R9

    for (int t = 0; t < 60; t++) begin
      c = 24'($urandom);
      k = $urandom_range(0, 3);
      b1 = $urandom_range(0, 23);
      b2 = (b1 + $urandom_range(1, 23)) % 24;
      case (k)
        0: x = 24'h0;
        1: x = 24'd1 << b1;
        2: x = (24'd1 << b1) | (24'd1 << b2);
        default: x = fix_syndrome($urandom_range(0, 511), $urandom_range(0, 7));
      endcase
      run_case(c ^ x, c, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule